// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block sits beside a small processor core and decides when the core should leave its program and enter an interrupt routine, and at which address. It watches three request sources: a USB event, an overflow of timer 0 and an overflow of timer 1. A one-cycle pulse from a source sets that source's pending flag. The flag holds its value until the request is served or software overwrites it. Each source has its own enable bit. A single master enable gates all three.

The core marks the point in its instruction phase where an interrupt may start by pulsing a sample strobe. At that strobe the block looks for pending and enabled sources. It only does so if the master enable is set and the core's return stack has room. It then picks the most urgent source, raises a one-cycle take pulse and presents that source's entry address. In the same edge it clears the chosen flag and drops the master enable, so the routine cannot be interrupted. The master enable comes back when the core signals a return that re-enables interrupts, or when software writes it.

Software reaches the flags, the enables and the master enable through one control word. The write port replaces the whole word. The read port shows its current contents.

Top module: `irq_vector_ctrl`

## Requirements
- R1: While reset is asserted, and in the cycle after release, `take` is 0, `vector` is 0 and `ctl_q` is all zeros (master enable, all source enables and all flags cleared).
- R2: A pulse on `src_pulse[i]` sets flag i at the next clock edge. Source 0 is USB, source 1 is timer 0 and source 2 is timer 1. The flag then stays set until its interrupt is taken or a control write clears it. If a pulse and a clearing event fall on the same edge, the pulse wins.
- R3: An interrupt is taken only at an edge where `sample_stb` is 1, the master enable is 1, and some source has both its flag and its enable set. `take` is 1 in the cycle after that edge and 0 in every other cycle. A request that arrives between two strobes waits for the next strobe.
- R4: When several sources qualify at once, the lowest source index wins: USB first, then timer 0, then timer 1.
- R5: While `take` is 1, `vector` is 0x04 for USB, 0x08 for timer 0 and 0x0C for timer 1. While `take` is 0, `vector` is 0.
- R6: The edge that takes an interrupt clears the winner's flag and clears the master enable. The other flags are left as they were.
- R7: A pulse on `reti_stb` sets the master enable at the next edge.
- R8: No interrupt is taken at a strobe while `stack_full` is 1. The request stays pending and is taken at a later strobe once `stack_full` is 0.
- R9: Control word layout: bit 0 is the master enable, bits 1..3 are the source enables and bits 4..6 are the flags, with the timer 1 flag at bit 6. A write with `ctl_wr_en` replaces all seven bits at the next edge, and `ctl_q` shows them. Setting the master enable by a write lets a pending request be taken at the next strobe.
- R10: If an interrupt is taken on the same edge as a `reti_stb` pulse or a control write, the master enable ends up cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_pulse | input | 3 | Request pulses: bit 0 USB, bit 1 timer 0, bit 2 timer 1 |
| stack_full | input | 1 | Core return stack has no free entry |
| sample_stb | input | 1 | Phase strobe at which an interrupt may be taken |
| reti_stb | input | 1 | Return that re-enables interrupts |
| ctl_wr_en | input | 1 | Write strobe for the control word |
| ctl_wr_data | input | 7 | Control word to write |
| ctl_q | output | 7 | Current control word |
| take | output | 1 | One-cycle interrupt entry request |
| vector | output | 8 | Entry address while `take` is high, else 0 |

## Verification
The bench builds the block with its default parameters: three sources, an 8-bit vector, base 0x04 and step 0x04. These match the USB and two-timer arrangement and make all three entry addresses and every two- and three-way priority collision reachable. Directed phases cover collisions, the stack-full hold-off, the return and write paths, and same-edge conflicts between a take and a re-enable. A long random phase then mixes pulses, strobes, stack-full, returns and writes. In that phase, pulses that arrive in the strobe cycle itself and writes that race a take are common.

// File: rtl/irq_pkg.sv
package irq_pkg;

  // Entry address of source idx: base plus a fixed stride per priority rank.
  function automatic int vec_addr(int idx, int base, int step);
    return base + idx * step;
  endfunction

  // Bit position of a field inside the control word.
  function automatic int en_pos(int idx);
    return 1 + idx;
  endfunction

  function automatic int flag_pos(int idx, int nsrc);
    return 1 + nsrc + idx;
  endfunction

endpackage

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int N     = 3,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     req,
  output logic [N-1:0]     grant_oh,
  output logic [IDX_W-1:0] grant_idx,
  output logic             grant_any
);

  // Lowest set bit wins: isolate it with two's complement.
  assign grant_oh  = req & (~req + N'(1));
  assign grant_any = |req;

  always_comb begin
    grant_idx = '0;
    for (int i = 0; i < N; i++) begin
      if (grant_oh[i]) grant_idx = IDX_W'(i);
    end
  end

endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] src_pulse,
  input  logic         wr_en,
  input  logic [N-1:0] wr_enables,
  input  logic [N-1:0] wr_flags,
  input  logic [N-1:0] served_oh,
  output logic [N-1:0] en_q,
  output logic [N-1:0] flag_q
);

  for (genvar i = 0; i < N; i++) begin : g_src
    logic flag_base;
    assign flag_base = wr_en ? wr_flags[i] : flag_q[i];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        flag_q[i] <= 1'b0;
        en_q[i]   <= 1'b0;
      end else begin
        flag_q[i] <= (flag_base & ~served_oh[i]) | src_pulse[i];
        if (wr_en) en_q[i] <= wr_enables[i];
      end
    end
  end

endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl #(
  parameter int N_SRC    = 3,
  parameter int VEC_W    = 8,
  parameter int VEC_BASE = 4,
  parameter int VEC_STEP = 4,
  localparam int CTL_W   = 2 * N_SRC + 1,
  localparam int IDX_W   = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] src_pulse,
  input  logic             stack_full,
  input  logic             sample_stb,
  input  logic             reti_stb,
  input  logic             ctl_wr_en,
  input  logic [CTL_W-1:0] ctl_wr_data,
  output logic [CTL_W-1:0] ctl_q,
  output logic             take,
  output logic [VEC_W-1:0] vector
);
  import irq_pkg::*;

  logic             master_q;
  logic [N_SRC-1:0] en_q, flag_q, req;
  logic [N_SRC-1:0] wr_en_bits, wr_flag_bits;
  logic [N_SRC-1:0] pick_oh, served_oh;
  logic [IDX_W-1:0] pick_idx;
  logic             pick_any, entry_ok, grant_now;

  // Control word slices
  for (genvar i = 0; i < N_SRC; i++) begin : g_slice
    assign wr_en_bits[i]   = ctl_wr_data[en_pos(i)];
    assign wr_flag_bits[i] = ctl_wr_data[flag_pos(i, N_SRC)];
  end

  assign req = flag_q & en_q;

  irq_prio_pick #(.N(N_SRC)) u_pick (
    .req       (req),
    .grant_oh  (pick_oh),
    .grant_idx (pick_idx),
    .grant_any (pick_any)
  );

  // Entry window: strobe phase, interrupts enabled, stack has room.
  assign entry_ok  = sample_stb & master_q & ~stack_full;
  assign grant_now = entry_ok & pick_any;
  assign served_oh = grant_now ? pick_oh : '0;

  irq_flag_bank #(.N(N_SRC)) u_bank (
    .clk        (clk),
    .rst_n      (rst_n),
    .src_pulse  (src_pulse),
    .wr_en      (ctl_wr_en),
    .wr_enables (wr_en_bits),
    .wr_flags   (wr_flag_bits),
    .served_oh  (served_oh),
    .en_q       (en_q),
    .flag_q     (flag_q)
  );

  // Master enable: a take dominates, then a write, then a re-enabling return.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         master_q <= 1'b0;
    else if (grant_now) master_q <= 1'b0;
    else if (ctl_wr_en) master_q <= ctl_wr_data[0];
    else if (reti_stb)  master_q <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      take   <= 1'b0;
      vector <= '0;
    end else begin
      take   <= grant_now;
      vector <= grant_now ? VEC_W'(vec_addr(int'(pick_idx), VEC_BASE, VEC_STEP)) : '0;
    end
  end

  assign ctl_q = {flag_q, en_q, master_q};

endmodule

// File: rtl/irq_vector_ctrl_chk.sv
module irq_vector_ctrl_chk #(
  parameter int N_SRC    = 3,
  parameter int VEC_W    = 8,
  parameter int VEC_BASE = 4,
  parameter int VEC_STEP = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sample_stb,
  input logic             stack_full,
  input logic             reti_stb,
  input logic             ctl_wr_en,
  input logic             take,
  input logic [VEC_W-1:0] vector,
  input logic             master,
  input logic             grant_now,
  input logic [N_SRC-1:0] served_oh
);

  // R3
  take_needs_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> $past(sample_stb));

  // R8
  stack_full_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> !$past(stack_full));

  // R6
  take_drops_master_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> !master);

  // R4
  single_winner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(served_oh));

  // R5
  vector_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> (int'(vector) >= VEC_BASE) &&
             (int'(vector) < VEC_BASE + N_SRC * VEC_STEP) &&
             ((int'(vector) - VEC_BASE) % VEC_STEP == 0));

  // R5
  vector_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !take |-> vector == '0);

  // R7
  reti_sets_master_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reti_stb && !grant_now && !ctl_wr_en |=> master);

  // R10
  take_beats_reenable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grant_now |=> !master);

endmodule

bind irq_vector_ctrl irq_vector_ctrl_chk #(
  .N_SRC(N_SRC), .VEC_W(VEC_W), .VEC_BASE(VEC_BASE), .VEC_STEP(VEC_STEP)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .sample_stb (sample_stb),
  .stack_full (stack_full),
  .reti_stb   (reti_stb),
  .ctl_wr_en  (ctl_wr_en),
  .take       (take),
  .vector     (vector),
  .master     (master_q),
  .grant_now  (grant_now),
  .served_oh  (served_oh)
);

// File: tb/tb_irq_vector_ctrl.sv
`timescale 1ns/1ps
module tb_irq_vector_ctrl;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] src_pulse = '0;
  logic       stack_full = 1'b0, sample_stb = 1'b0, reti_stb = 1'b0, ctl_wr_en = 1'b0;
  logic [6:0] ctl_wr_data = '0;
  logic [6:0] ctl_q;
  logic       take;
  logic [7:0] vector;

  always #2.5 clk = ~clk;

  irq_vector_ctrl dut (
    .clk(clk), .rst_n(rst_n), .src_pulse(src_pulse), .stack_full(stack_full),
    .sample_stb(sample_stb), .reti_stb(reti_stb), .ctl_wr_en(ctl_wr_en),
    .ctl_wr_data(ctl_wr_data), .ctl_q(ctl_q), .take(take), .vector(vector)
  );

  int    n_checks = 0, n_fail = 0;
  string cur_req = "R1";
  bit    done = 0;

  // Behavioural reference model
  bit m_master = 0;
  bit m_en[3]   = '{0, 0, 0};
  bit m_flag[3] = '{0, 0, 0};
  bit exp_take = 0;
  int exp_vec  = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_master = 0; exp_take = 0; exp_vec = 0;
      foreach (m_en[k]) begin m_en[k] = 0; m_flag[k] = 0; end
    end else begin
      int winner;
      winner = -1;
      if (sample_stb && m_master && !stack_full)
        for (int k = 0; k < 3; k++)
          if (winner < 0 && m_flag[k] && m_en[k]) winner = k;
      for (int k = 0; k < 3; k++) begin
        bit f;
        f = ctl_wr_en ? ctl_wr_data[4 + k] : m_flag[k];
        if (k == winner) f = 0;
        if (src_pulse[k]) f = 1;
        m_flag[k] = f;
        if (ctl_wr_en) m_en[k] = ctl_wr_data[1 + k];
      end
      if (winner >= 0)    m_master = 0;
      else if (ctl_wr_en) m_master = ctl_wr_data[0];
      else if (reti_stb)  m_master = 1;
      exp_take = (winner >= 0);
      exp_vec  = (winner >= 0) ? 4 * (winner + 1) : 0;
    end
  end

  function automatic int exp_ctl();
    int v;
    v = m_master;
    for (int k = 0; k < 3; k++) v |= (m_en[k] << (1 + k)) | (m_flag[k] << (4 + k));
    return v;
  endfunction

  task automatic chk(string what, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h at %0t", cur_req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("take", int'(take), int'(exp_take));
      chk("vector", int'(vector), exp_vec);
      chk("ctl_q", int'(ctl_q), exp_ctl());
    end
  end

  task automatic cyc(logic [2:0] p = 3'b0, bit stb = 0, bit full = 0, bit reti = 0,
                     bit wr = 0, logic [6:0] wd = 7'h0);
    src_pulse = p; sample_stb = stb; stack_full = full; reti_stb = reti;
    ctl_wr_en = wr; ctl_wr_data = wd;
    @(negedge clk);
    src_pulse = '0; sample_stb = 0; stack_full = 0; reti_stb = 0; ctl_wr_en = 0;
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) cyc();
  endtask

  initial begin
    #(200000 * 5);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    cur_req = "R1";
    chk("reset take", int'(take), 0);
    chk("reset vector", int'(vector), 0);
    chk("reset ctl", int'(ctl_q), 0);
    rst_n = 1;
    idle(2);

    cur_req = "R2";                  // flags latch and hold
    cyc(3'b010); idle(4);
    cyc(3'b101); idle(3);
    cur_req = "R9";                  // write clears flags, sets enables
    cyc(, , , , 1, 7'h0E); idle(2);
    cur_req = "R3";                  // no strobe, or master off: nothing taken
    cyc(3'b111); idle(5);
    cyc(, 1); idle(2);
    cur_req = "R9";                  // enable master by write, then strobe
    cyc(, , , , 1, 7'h7F); idle(1);
    cur_req = "R4";
    cyc(, 1); idle(2);               // USB wins
    cur_req = "R6";
    cyc(, 1); idle(2);               // master off: no take
    cur_req = "R7";
    cyc(, , , 1); cyc(, 1); idle(2); // timer 0
    cur_req = "R5";
    cyc(, , , 1); cyc(, 1); idle(2); // timer 1
    cur_req = "R8";                  // stack full holds off
    cyc(, , , , 1, 7'h5F);
    cyc(, 1, 1); cyc(, 1, 1); idle(2);
    cyc(, 1); idle(2);
    cur_req = "R3";                  // disabled source is not taken
    cyc(, , , , 1, 7'h35); cyc(, 1); idle(2);
    cyc(3'b100, 1); idle(1); cyc(, 1); idle(2);
    cur_req = "R10";                 // take beats reti and write
    cyc(, , , , 1, 7'h7F);
    cyc(, 1, , 1); idle(2);
    cyc(, , , , 1, 7'h7F);
    cyc(, 1, , , 1, 7'h7F); idle(2);
    cur_req = "R2";                  // pulse on the serving edge survives
    cyc(, , , , 1, 7'h13);
    cyc(3'b001, 1); idle(2);

    cur_req = "R4";                  // random mix
    for (int k = 0; k < 4000; k++) begin
      cyc(3'(($urandom % 8 == 0) ? $urandom : 0),
          ($urandom % 3 == 0), ($urandom % 5 == 0), ($urandom % 5 == 0),
          ($urandom % 25 == 0), 7'($urandom | 7'h0F));
    end
    idle(3);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

endmodule